// File: doc/BRIEF.md
# Temperature Limit Interrupt Controller

This block turns conversion results from two temperature sensors, one on the die and one on a remote diode, into a latched interrupt status byte. It also takes over-temperature flags, a diode-fault flag and one general-purpose input. Every temperature reading is compared as a signed value against its own high and low limit. A source counts as out of limit only after several consecutive conversions agree. The result then drives a single active-low interrupt line through a per-bit mask and a global enable.

Software reaches the block through a plain write strobe and a combinational read port with three registers: status (address 0), mask (address 1) and configuration (address 2). Hardware-detected bits are cleared by writing one to them. After a clear, the source stays quiet until the reading has been back in limit for the same number of conversions. Two software flag bits let firmware raise an interrupt by itself. A self-clearing configuration bit restores the defaults and rearms every source.

Top module: `temp_irq_ctrl`

## Requirements
- R1: After reset, status reads 0x00, mask reads 0x00, configuration reads 0x21 and `int_n` is high. Status is at address 0, mask at address 1 and configuration at address 2.
- R2: Status bit 0 (internal temperature) and bit 5 (external temperature) set only after QUAL_RUNS consecutive `conv_done` strobes on which the signed reading is strictly above its high limit or strictly below its low limit. A reading equal to a limit is in limit. Any in-limit conversion restarts the run.
- R3: After software clears a hardware status bit, that bit is not set again while the source stays out of limit. The source rearms only after QUAL_RUNS consecutive in-limit conversions, and then needs QUAL_RUNS more out-of-limit conversions to set.
- R4: Writing 1 to status bits 0, 3, 5, 6 or 7 clears that bit. Writing 0 to those bits leaves them unchanged.
- R5: Status bits 1 and 2 are software flags. A status write loads them directly from the written data, so 1 sets a flag and 0 clears it.
- R6: Status bit 4 is not latched. It always reads as `gpi` XOR configuration bit 6, and status writes never change it.
- R7: A mask bit of 1 removes the matching status bit from the interrupt, while the status bit itself still updates.
- R8: `int_n` is low when configuration bit 1 is 1 and any unmasked status bit is 1. With configuration bit 1 at 0, status bits alone never drive `int_n` low.
- R9: `int_n` is low whenever `therm_active` is high, regardless of mask and enable.
- R10: Writing configuration bit 4 as 1 is a soft reset. Configuration returns to 0x21, and status and mask return to 0x00. Every source is rearmed at once, so QUAL_RUNS out-of-limit conversions set its bit again. Configuration bit 4 always reads 0.
- R11: When a hardware set and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R12: Status bits 3 (`therm_int_flag`), 6 (`therm_ext_flag`) and 7 (`diode_fault`) are qualified like the temperature bits, requiring QUAL_RUNS consecutive conversions with the flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe, new readings and flags valid |
| temp_int | input | DATA_W | Internal sensor reading, two's complement |
| temp_ext | input | DATA_W | External diode reading, two's complement |
| int_hi | input | DATA_W | Internal high limit, signed |
| int_lo | input | DATA_W | Internal low limit, signed |
| ext_hi | input | DATA_W | External high limit, signed |
| ext_lo | input | DATA_W | External low limit, signed |
| therm_int_flag | input | 1 | Internal over-temperature flag |
| therm_ext_flag | input | 1 | External over-temperature flag |
| diode_fault | input | 1 | Remote diode open or short flag |
| gpi | input | 1 | General-purpose input level |
| therm_active | input | 1 | Over-temperature output currently asserted |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 8 | Read data (combinational) |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its defaults, DATA_W = 8 and QUAL_RUNS = 3. With these values the signed extremes such as -128 against a zero low limit can be driven, and readings can sit exactly on a limit. A three-conversion run is short enough to stop at two, restart and reach three within a few strobes. The run counter also reaches its saturation value, so a held out-of-limit condition and the rearm window after a clear can both be walked conversion by conversion.

// File: rtl/temp_irq_pkg.sv
package temp_irq_pkg;
    // Status / mask bit positions (decoded by software, order is fixed)
    localparam int unsigned ST_INT_TEMP  = 0;
    localparam int unsigned ST_FLAG_A    = 1;
    localparam int unsigned ST_FLAG_B    = 2;
    localparam int unsigned ST_INT_THERM = 3;
    localparam int unsigned ST_GPI       = 4;
    localparam int unsigned ST_EXT_TEMP  = 5;
    localparam int unsigned ST_EXT_THERM = 6;
    localparam int unsigned ST_DIODE     = 7;

    // Configuration bits
    localparam int unsigned CFG_INT_EN   = 1;
    localparam int unsigned CFG_SOFT_RST = 4;
    localparam int unsigned CFG_GPI_INV  = 6;

    localparam logic [7:0] CFG_DEFAULT = 8'h21;
    localparam logic [7:0] HW_BITS     = 8'hE9;  // qualified, write-one-to-clear
    localparam logic [7:0] SW_BITS     = 8'h06;  // software flags

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_CONFIG = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/temp_src_qual.sv
module temp_src_qual #(
    parameter int unsigned QUAL_RUNS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic conv_done,
    input  logic out_of_lim,
    input  logic clr_req,
    output logic set_o
);
    localparam int unsigned CNT_W = $clog2(QUAL_RUNS + 1);
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(QUAL_RUNS);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic [CNT_W-1:0] run_inc;

    always_comb begin
        st_d    = st_q;
        set_o   = 1'b0;
        run_inc = (st_q.cnt == RUN_MAX) ? st_q.cnt : st_q.cnt + 1'b1;
        if (conv_done) begin
            if (st_q.armed) begin
                if (out_of_lim) begin
                    st_d.cnt = run_inc;
                    set_o    = (run_inc == RUN_MAX);
                end else begin
                    st_d.cnt = '0;
                end
            end else begin
                if (!out_of_lim) begin
                    if (run_inc == RUN_MAX) begin
                        st_d.armed = 1'b1;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = run_inc;
                    end
                end else begin
                    st_d.cnt = '0;
                end
            end
        end
        if (clr_req && !set_o) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end
        if (soft_rst) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed <= 1'b1;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a disarmed source never raises a set
    a_r3_disarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |-> !set_o);
    // R3: an effective clear disarms the source
    a_r3_clear_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_o && !soft_rst) |=> !st_q.armed);
    // R10: soft reset rearms with an empty run
    a_r10_soft_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_q.armed && st_q.cnt == '0));
    // R2: run counter never passes the qualification length
    a_r2_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= RUN_MAX);
    // R2: a set needs the run to have been one short of (or at) the limit
    a_r2_set_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        set_o |-> (st_q.cnt >= RUN_MAX - 1'b1));
endmodule

// File: rtl/temp_irq_ctrl.sv
module temp_irq_ctrl
    import temp_irq_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned QUAL_RUNS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     conv_done,
    input  logic signed [DATA_W-1:0] temp_int,
    input  logic signed [DATA_W-1:0] temp_ext,
    input  logic signed [DATA_W-1:0] int_hi,
    input  logic signed [DATA_W-1:0] int_lo,
    input  logic signed [DATA_W-1:0] ext_hi,
    input  logic signed [DATA_W-1:0] ext_lo,
    input  logic                     therm_int_flag,
    input  logic                     therm_ext_flag,
    input  logic                     diode_fault,
    input  logic                     gpi,
    input  logic                     therm_active,
    input  logic                     wr_en,
    input  logic [1:0]               wr_addr,
    input  logic [7:0]               wr_data,
    input  logic [1:0]               rd_addr,
    output logic [7:0]               rd_data,
    output logic                     int_n
);
    localparam int unsigned NBITS = 8;

    typedef struct packed {
        logic [7:0] cfg;
        logic [7:0] mask;
        logic [7:0] status;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NBITS-1:0] hw_cond;
    logic [NBITS-1:0] set_vec;
    logic [NBITS-1:0] clr_vec;
    logic [7:0]       status_vis;
    logic             wr_status, wr_mask, wr_cfg, soft_rst;

    assign wr_status = wr_en && (reg_sel_e'(wr_addr) == SEL_STATUS);
    assign wr_mask   = wr_en && (reg_sel_e'(wr_addr) == SEL_MASK);
    assign wr_cfg    = wr_en && (reg_sel_e'(wr_addr) == SEL_CONFIG);
    assign soft_rst  = wr_cfg && wr_data[CFG_SOFT_RST];

    always_comb begin
        hw_cond               = '0;
        hw_cond[ST_INT_TEMP]  = (temp_int > int_hi) || (temp_int < int_lo);
        hw_cond[ST_EXT_TEMP]  = (temp_ext > ext_hi) || (temp_ext < ext_lo);
        hw_cond[ST_INT_THERM] = therm_int_flag;
        hw_cond[ST_EXT_THERM] = therm_ext_flag;
        hw_cond[ST_DIODE]     = diode_fault;
    end

    assign clr_vec = wr_status ? (wr_data & HW_BITS) : '0;

    for (genvar i = 0; i < NBITS; i++) begin : g_src
        if (HW_BITS[i]) begin : g_qual
            temp_src_qual #(.QUAL_RUNS(QUAL_RUNS)) u_qual (
                .clk        (clk),
                .rst_n      (rst_n),
                .soft_rst   (soft_rst),
                .conv_done  (conv_done),
                .out_of_lim (hw_cond[i]),
                .clr_req    (clr_vec[i]),
                .set_o      (set_vec[i])
            );
        end else begin : g_none
            assign set_vec[i] = 1'b0;
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_status) begin
            regs_d.status = (regs_q.status & ~clr_vec & ~SW_BITS) | (wr_data & SW_BITS);
        end
        regs_d.status = regs_d.status | set_vec;   // hardware set wins
        if (wr_mask) regs_d.mask = wr_data;
        if (wr_cfg)  regs_d.cfg  = wr_data & ~(8'h1 << CFG_SOFT_RST);
        if (soft_rst) begin
            regs_d.cfg    = CFG_DEFAULT;
            regs_d.mask   = '0;
            regs_d.status = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.cfg    <= CFG_DEFAULT;
            regs_q.mask   <= '0;
            regs_q.status <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        status_vis         = regs_q.status;
        status_vis[ST_GPI] = gpi ^ regs_q.cfg[CFG_GPI_INV];
    end

    always_comb begin
        case (reg_sel_e'(rd_addr))
            SEL_STATUS: rd_data = status_vis;
            SEL_MASK:   rd_data = regs_q.mask;
            SEL_CONFIG: rd_data = regs_q.cfg;
            default:    rd_data = '0;
        endcase
    end

    assign int_n = !(((|(status_vis & ~regs_q.mask)) && regs_q.cfg[CFG_INT_EN]) || therm_active);

    // R9: over-temperature output always pulls the interrupt
    a_r9_therm_forces_int: assert property (@(posedge clk) disable iff (!rst_n)
        therm_active |-> !int_n);
    // R8: with the enable off and no over-temperature, the line stays high
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.cfg[CFG_INT_EN] && !therm_active) |-> int_n);
    // R11: a hardware set is never lost to a simultaneous clear
    a_r11_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((|set_vec) && !soft_rst) |=> ((regs_q.status & $past(set_vec)) == $past(set_vec)));
    // R4: an uncontested write-one clears the bit
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && ((clr_vec & set_vec) == '0)) |=> ((regs_q.status & $past(clr_vec)) == '0));
    // R10: soft reset restores defaults
    a_r10_soft_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (regs_q.cfg == CFG_DEFAULT && regs_q.mask == '0 && regs_q.status == '0));
endmodule

// File: tb/tb_temp_irq_ctrl.sv
module tb_temp_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_done = 1'b0;
    logic signed [7:0] temp_int = 8'sd20, temp_ext = 8'sd40;
    logic signed [7:0] int_hi = 8'sd50, int_lo = -8'sd10, ext_hi = 8'sd90, ext_lo = 8'sd0;
    logic therm_int_flag = 1'b0, therm_ext_flag = 1'b0, diode_fault = 1'b0;
    logic gpi = 1'b0, therm_active = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic int_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    temp_irq_ctrl #(.DATA_W(8), .QUAL_RUNS(3)) dut (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done),
        .temp_int(temp_int), .temp_ext(temp_ext),
        .int_hi(int_hi), .int_lo(int_lo), .ext_hi(ext_hi), .ext_lo(ext_lo),
        .therm_int_flag(therm_int_flag), .therm_ext_flag(therm_ext_flag),
        .diode_fault(diode_fault), .gpi(gpi), .therm_active(therm_active),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .int_n(int_n)
    );

    // flags field is {diode_fault, therm_ext_flag, therm_int_flag}
    typedef struct packed {
        logic [7:0] ti;
        logic [7:0] te;
        logic [2:0] fl;
        logic [7:0] exp_st;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{8'd50,  8'd90,  3'b000, 8'h00},  // on limits: in limit
        '{8'd60,  8'd40,  3'b000, 8'h00},  // int run 1
        '{8'd60,  8'd40,  3'b000, 8'h00},  // int run 2
        '{8'hF6,  8'd40,  3'b000, 8'h00},  // -10 equals low: run restarts
        '{8'hEC,  8'd40,  3'b000, 8'h00},  // -20 run 1
        '{8'hEC,  8'd40,  3'b000, 8'h00},  // run 2
        '{8'hEC,  8'd40,  3'b000, 8'h01},  // run 3: bit 0
        '{8'd20,  8'd95,  3'b000, 8'h01},  // ext high run 1
        '{8'd20,  8'h80,  3'b000, 8'h01},  // -128 below low: run 2
        '{8'd20,  8'd95,  3'b000, 8'h21},  // run 3: bit 5
        '{8'd20,  8'd40,  3'b001, 8'h21},
        '{8'd20,  8'd40,  3'b001, 8'h21},
        '{8'd20,  8'd40,  3'b001, 8'h29},  // bit 3
        '{8'd20,  8'd40,  3'b110, 8'h29},
        '{8'd20,  8'd40,  3'b110, 8'h29},
        '{8'd20,  8'd40,  3'b110, 8'hE9}   // bits 6, 7
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic chk_int(input string req, input logic exp);
        #1;
        chk(req, {7'd0, int_n}, {7'd0, exp});
    endtask

    task automatic conv(input logic [7:0] ti, input logic [7:0] te, input logic [2:0] fl);
        @(negedge clk);
        temp_int = ti; temp_ext = te;
        {diode_fault, therm_ext_flag, therm_int_flag} = fl;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic conv_wr(input logic [7:0] ti, input logic [7:0] te, input logic [2:0] fl,
                           input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        temp_int = ti; temp_ext = te;
        {diode_fault, therm_ext_flag, therm_int_flag} = fl;
        conv_done = 1'b1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        conv_done = 1'b0;
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_reg("R1 status reset", 2'd0, 8'h00);
        chk_reg("R1 mask reset", 2'd1, 8'h00);
        chk_reg("R1 config reset", 2'd2, 8'h21);
        chk_int("R1 int_n reset", 1'b1);

        // R2 / R12 qualification table
        for (int i = 0; i < 16; i++) begin
            conv(VECS[i].ti, VECS[i].te, VECS[i].fl);
            chk_reg($sformatf("R2/R12 vector %0d", i), 2'd0, VECS[i].exp_st);
        end

        // R4 write-one-to-clear
        wr(2'd0, 8'h00);
        chk_reg("R4 write zero keeps", 2'd0, 8'hE9);
        wr(2'd0, 8'h01);
        chk_reg("R4 write one clears", 2'd0, 8'hE8);

        // R3 disarm and rearm
        for (int i = 0; i < 3; i++) begin
            conv(8'd60, 8'd40, 3'b110);
            chk_reg("R3 stays clear while out", 2'd0, 8'hE8);
        end
        for (int i = 0; i < 3; i++) begin
            conv(8'd20, 8'd40, 3'b110);
            chk_reg("R3 in-limit rearm window", 2'd0, 8'hE8);
        end
        conv(8'd60, 8'd40, 3'b110);
        conv(8'd60, 8'd40, 3'b110);
        chk_reg("R3 two after rearm", 2'd0, 8'hE8);
        conv(8'd60, 8'd40, 3'b110);
        chk_reg("R3 third after rearm sets", 2'd0, 8'hE9);

        // R5 software flags
        wr(2'd0, 8'h06);
        chk_reg("R5 flags set", 2'd0, 8'hEF);
        wr(2'd0, 8'h00);
        chk_reg("R5 flags cleared by zero", 2'd0, 8'hE9);
        wr(2'd0, 8'h02);
        chk_reg("R5 flag A only", 2'd0, 8'hEB);

        // R6 live GPI bit
        gpi = 1'b1;
        chk_reg("R6 gpi high", 2'd0, 8'hFB);
        wr(2'd0, 8'h12);
        chk_reg("R6 write ignores bit 4", 2'd0, 8'hFB);
        wr(2'd2, 8'h61);
        chk_reg("R6 inverted gpi high", 2'd0, 8'hEB);
        gpi = 1'b0;
        chk_reg("R6 inverted gpi low", 2'd0, 8'hFB);
        wr(2'd2, 8'h21);
        chk_reg("R6 plain gpi low", 2'd0, 8'hEB);

        // R8 / R7 interrupt gating
        chk_int("R8 enable off keeps int_n high", 1'b1);
        wr(2'd2, 8'h23);
        chk_int("R8 enable on asserts", 1'b0);
        wr(2'd1, 8'hFF);
        chk_int("R7 full mask deasserts", 1'b1);
        chk_reg("R7 status unchanged by mask", 2'd0, 8'hEB);
        wr(2'd0, 8'hF9);
        chk_reg("R4 clear all hardware bits", 2'd0, 8'h00);
        wr(2'd0, 8'h02);
        chk_reg("R7 masked bit still sets", 2'd0, 8'h02);
        chk_int("R7 masked bit no int", 1'b1);
        wr(2'd1, 8'hFD);
        chk_int("R7 unmasked bit asserts", 1'b0);
        wr(2'd0, 8'h00);
        chk_int("R8 no status deasserts", 1'b1);

        // R9 over-temperature override
        therm_active = 1'b1;
        chk_int("R9 therm asserts int", 1'b0);
        therm_active = 1'b0;
        chk_int("R9 therm released", 1'b1);

        // R10 soft reset
        wr(2'd1, 8'h55);
        wr(2'd0, 8'h04);
        wr(2'd2, 8'h10);
        chk_reg("R10 config default", 2'd2, 8'h21);
        chk_reg("R10 status cleared", 2'd0, 8'h00);
        chk_reg("R10 mask cleared", 2'd1, 8'h00);
        chk_int("R10 int_n high", 1'b1);
        conv(8'd60, 8'd40, 3'b000);
        conv(8'd60, 8'd40, 3'b000);
        chk_reg("R10 two runs after soft reset", 2'd0, 8'h00);
        conv(8'd60, 8'd40, 3'b000);
        chk_reg("R10 rearmed without in-limit wait", 2'd0, 8'h01);

        // R11 hardware set beats clear
        conv(8'd20, 8'd95, 3'b000);
        conv(8'd20, 8'd95, 3'b000);
        conv_wr(8'd20, 8'd95, 3'b000, 2'd0, 8'h20);
        chk_reg("R11 set wins over clear", 2'd0, 8'h21);
        wr(2'd0, 8'h20);
        chk_reg("R11 later clear takes effect", 2'd0, 8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule